// File: doc/BRIEF.md
# Link Self-Test Sequencer

This block is the control state machine at the receiving end of a high-speed serial link. It starts an at-speed link self-test and steps it through its phases. A rising edge on the test-enable input latches a 2-bit clock-select code. That code either picks one of three internal pixel-clock rates or hands the clock over to an external source. The sequencer then issues a single-cycle request asking the back-channel to send an "enter test mode" command to the far-end transmitter.

After the request, the sequencer opens a lock-acquisition window of a fixed number of millisecond ticks. The window is ten ticks by default. The test counts as running only once the receiver's lock indication is seen to go from low to high inside that window. If the window runs out first, the sequencer flags a timeout and falls back to idle. If lock is lost while the test runs, the sequencer goes back to waiting for lock with a fresh window. Dropping the enable returns it to idle from any phase.

The back-channel physical layer, the oscillator and the pattern checker are outside this block. The sequencer drives only their control lines.

Top module: `link_selftest_seq`

## Requirements
- R1: After reset the sequencer is idle: `cmd_req_o`, `test_run_o`, `timeout_err_o`, `osc_bypass_o` are 0 and `osc_sel_o` is 3'b000.
- R2: In idle, a rising edge of `test_en_i` makes `cmd_req_o` high for exactly one cycle, in the cycle after the edge is sampled.
- R3: From that cycle until the sequencer returns to idle, the clock outputs follow the latched code. Code 01 gives `osc_sel_o`=3'b001 (50 MHz). Code 10 gives 3'b010 (25 MHz). Code 11 gives 3'b100 (12.5 MHz). In each of these cases `osc_bypass_o`=0. Code 00 gives `osc_sel_o`=3'b000 with `osc_bypass_o`=1 (external clock, nominally 10 to 43 MHz). In idle, both clock outputs are 0.
- R4: Changes on `clk_sel_i` after the enable edge has been sampled have no effect on the clock outputs.
- R5: While `test_en_i` stays high, `cmd_req_o` is not raised again. A new request needs `test_en_i` to go low and then high.
- R6: While waiting for lock, a low-to-high transition of `lock_i` sets `test_run_o` in the next cycle. A `lock_i` that is already high on entry to the wait does not start the test.
- R7: If the `LOCK_WIN_MS`-th `ms_tick_i` of a wait arrives without a lock rising edge, the sequencer returns to idle with `timeout_err_o`=1. The flag holds until the next enable rising edge clears it.
- R8: `lock_i` going low while running clears `test_run_o` in the next cycle. The sequencer then waits for lock again with a full new window.
- R9: `test_en_i` low returns the sequencer to idle in the next cycle from any phase. It clears `test_run_o` and does not set `timeout_err_o`.
- R10: A lock rising edge in the same cycle as the window-expiring tick starts the test and raises no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en_i | input | 1 | Self-test enable |
| clk_sel_i | input | 2 | Pixel-clock source code, latched on the enable edge |
| lock_i | input | 1 | Receiver lock indication |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| osc_sel_o | output | 3 | One-hot internal rate select: bit0 50 MHz, bit1 25 MHz, bit2 12.5 MHz |
| osc_bypass_o | output | 1 | Bypass internal oscillator, use external pixel clock |
| cmd_req_o | output | 1 | One-cycle request to send the enter-test command on the back-channel |
| test_run_o | output | 1 | Self-test operational |
| timeout_err_o | output | 1 | Lock window expired without lock |

## Verification
The bench sweeps all four clock-select codes. For each code it scrambles the select input after latching, which catches a design that decodes the live input instead of the latched code. Lock rises exactly on the expiring tick, which catches a design that lets the timeout win. The bench also counts ticks one short of the window and then exactly at it; an off-by-one counter times out early or late. Further cases cover lock already high on entry, which a level-sensitive design would wrongly accept as a start, and enable held high across a timeout, which a design reissuing the command would expose with a second request pulse.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_t;

  localparam int SEL_W  = 2;
  localparam int RATE_N = 3;

  // one-hot internal rate for a select code; code 0 selects no internal rate
  function automatic logic [RATE_N-1:0] rate_onehot(input logic [SEL_W-1:0] code);
    logic [RATE_N-1:0] r;
    r = '0;
    for (int i = 1; i <= RATE_N; i++) begin
      if (int'(code) == i) r[i-1] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic code_is_bypass(input logic [SEL_W-1:0] code);
    return code == '0;
  endfunction

endpackage

// File: rtl/lsq_rise_det.sv
module lsq_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/lsq_ms_window.sv
module lsq_ms_window #(
  parameter int WIN_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(WIN_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_MS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = active_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active_i) cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lsq_clk_cfg.sv
module lsq_clk_cfg
  import lsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] code_i,
  input  logic             active_i,
  output logic [RATE_N-1:0] osc_sel_o,
  output logic             osc_bypass_o
);
  logic [SEL_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= '0;
    else if (load_i) code_q <= code_i;
  end

  assign osc_sel_o    = active_i ? rate_onehot(code_q) : '0;
  assign osc_bypass_o = active_i & code_is_bypass(code_q);
endmodule

// File: rtl/link_selftest_seq.sv
module link_selftest_seq
  import lsq_pkg::*;
#(
  parameter int LOCK_WIN_MS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en_i,
  input  logic [1:0] clk_sel_i,
  input  logic       lock_i,
  input  logic       ms_tick_i,
  output logic [2:0] osc_sel_o,
  output logic       osc_bypass_o,
  output logic       cmd_req_o,
  output logic       test_run_o,
  output logic       timeout_err_o
);
  seq_state_t state_q, state_d;

  // named internal events
  logic en_rise, lock_rise, win_expire, in_wait, start_ok, timed_out, cfg_load;

  lsq_rise_det u_en_edge   (.clk(clk), .rst_n(rst_n), .d_i(test_en_i), .rise_o(en_rise));
  lsq_rise_det u_lock_edge (.clk(clk), .rst_n(rst_n), .d_i(lock_i),    .rise_o(lock_rise));

  assign in_wait = (state_q == ST_WAIT);

  lsq_ms_window #(.WIN_MS(LOCK_WIN_MS)) u_win (
    .clk(clk), .rst_n(rst_n), .active_i(in_wait),
    .tick_i(ms_tick_i), .expire_o(win_expire)
  );

  assign cfg_load  = (state_q == ST_IDLE) & en_rise;
  assign start_ok  = in_wait & test_en_i & lock_rise;
  assign timed_out = in_wait & test_en_i & win_expire & ~lock_rise;

  lsq_clk_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .code_i(clk_sel_i),
    .active_i(state_q != ST_IDLE),
    .osc_sel_o(osc_sel_o), .osc_bypass_o(osc_bypass_o)
  );

  always_comb begin
    state_d = state_q;
    if (!test_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (en_rise) state_d = ST_SEND;
        ST_SEND: state_d = ST_WAIT;
        ST_WAIT: begin
          if (start_ok)       state_d = ST_RUN;
          else if (timed_out) state_d = ST_IDLE;
        end
        ST_RUN:  if (!lock_i) state_d = ST_WAIT;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         timeout_err_o <= 1'b0;
    else if (cfg_load)  timeout_err_o <= 1'b0;
    else if (timed_out) timeout_err_o <= 1'b1;
  end

  assign cmd_req_o  = (state_q == ST_SEND);
  assign test_run_o = (state_q == ST_RUN);
endmodule

// File: rtl/link_selftest_seq_chk.sv
module link_selftest_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_en_i,
  input logic       cmd_req_o,
  input logic       test_run_o,
  input logic       timeout_err_o,
  input logic [2:0] osc_sel_o,
  input logic       osc_bypass_o,
  input logic       en_rise,
  input logic       lock_rise,
  input logic       timed_out
);
  // R2
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |=> !cmd_req_o);
  // R2
  cmd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> $past(en_rise));
  // R3
  osc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_sel_o) && !(osc_bypass_o && osc_sel_o != 3'b000));
  // R4
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_run_o && $past(test_run_o)) |-> ($stable(osc_sel_o) && $stable(osc_bypass_o)));
  // R6
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_run_o) |-> $past(lock_rise));
  // R7
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> (timeout_err_o && !test_run_o && osc_sel_o == 3'b000 && !osc_bypass_o));
  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en_i |=> (!test_run_o && !cmd_req_o));
endmodule

bind link_selftest_seq link_selftest_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_en_i(test_en_i),
  .cmd_req_o(cmd_req_o), .test_run_o(test_run_o), .timeout_err_o(timeout_err_o),
  .osc_sel_o(osc_sel_o), .osc_bypass_o(osc_bypass_o),
  .en_rise(en_rise), .lock_rise(lock_rise), .timed_out(timed_out)
);

// File: tb/link_selftest_seq_bench.sv
module link_selftest_seq_bench;
  localparam int WIN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en_i = 1'b0;
  logic [1:0] clk_sel_i = 2'b00;
  logic lock_i = 1'b0;
  logic ms_tick_i = 1'b0;
  logic [2:0] osc_sel_o;
  logic osc_bypass_o, cmd_req_o, test_run_o, timeout_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_selftest_seq #(.LOCK_WIN_MS(WIN)) u_link_selftest_seq (
    .clk(clk), .rst_n(rst_n), .test_en_i(test_en_i), .clk_sel_i(clk_sel_i),
    .lock_i(lock_i), .ms_tick_i(ms_tick_i), .osc_sel_o(osc_sel_o),
    .osc_bypass_o(osc_bypass_o), .cmd_req_o(cmd_req_o), .test_run_o(test_run_o),
    .timeout_err_o(timeout_err_o)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sel(input int code);
    return (code == 0) ? 0 : (1 << (code - 1));
  endfunction

  // outputs of the sequencer as {cmd,run,err,bypass,sel}
  function automatic int pack_out();
    return {cmd_req_o, test_run_o, timeout_err_o, osc_bypass_o, osc_sel_o};
  endfunction

  task automatic tick();
    ms_tick_i = 1'b1; cyc(); ms_tick_i = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1
    chk("R1", "idle outputs", pack_out(), 0);

    for (int code = 0; code < 4; code++) begin
      clk_sel_i = 2'(code);
      test_en_i = 1'b1;
      cyc();
      chk("R2", "cmd pulse", cmd_req_o, 1);
      chk("R3", "osc_sel", osc_sel_o, exp_sel(code));
      chk("R3", "bypass", osc_bypass_o, code == 0);
      clk_sel_i = ~2'(code);
      cyc();
      chk("R2", "cmd single", cmd_req_o, 0);
      chk("R4", "osc_sel after select change", osc_sel_o, exp_sel(code));
      chk("R4", "bypass after select change", osc_bypass_o, code == 0);
      for (int t = 0; t < WIN - 1; t++) tick();
      chk("R7", "no early timeout", timeout_err_o, 0);
      chk("R6", "not running before lock", test_run_o, 0);
      // R10: lock edge on the expiring tick
      lock_i = 1'b1; ms_tick_i = 1'b1; cyc(); ms_tick_i = 1'b0;
      chk("R10", "run on expiring tick", test_run_o, 1);
      chk("R10", "no timeout", timeout_err_o, 0);
      repeat (3) cyc();
      chk("R5", "no reissue", cmd_req_o, 0);
      chk("R4", "osc held in run", osc_sel_o, exp_sel(code));
      lock_i = 1'b0; cyc();
      chk("R8", "run cleared on lock loss", test_run_o, 0);
      chk("R8", "still configured", osc_bypass_o, code == 0);
      for (int t = 0; t < WIN - 1; t++) tick();
      chk("R8", "full new window", timeout_err_o, 0);
      tick();
      chk("R7", "timeout flag", timeout_err_o, 1);
      chk("R7", "idle after timeout", {test_run_o, osc_bypass_o, osc_sel_o}, 0);
      repeat (3) cyc();
      chk("R5", "no reissue after timeout", cmd_req_o, 0);
      chk("R7", "flag sticky", timeout_err_o, 1);
      test_en_i = 1'b0; cyc();
      chk("R7", "flag kept over disable", timeout_err_o, 1);
      clk_sel_i = 2'(code);
      test_en_i = 1'b1; cyc();
      chk("R5", "reissue after fresh enable", cmd_req_o, 1);
      chk("R7", "flag cleared", timeout_err_o, 0);
      cyc();
      lock_i = 1'b1; cyc();
      chk("R6", "run", test_run_o, 1);
      test_en_i = 1'b0; cyc();
      chk("R9", "disable from run", pack_out(), 0);
      lock_i = 1'b0; cyc();
    end

    // R6: lock already high on entry is not a start
    lock_i = 1'b1; cyc();
    clk_sel_i = 2'b10; test_en_i = 1'b1; cyc(); cyc();
    repeat (4) cyc();
    chk("R6", "level lock ignored", test_run_o, 0);
    lock_i = 1'b0; cyc();
    lock_i = 1'b1; cyc();
    chk("R6", "run after fresh edge", test_run_o, 1);

    // R9: disable during wait sets no error
    lock_i = 1'b0; cyc();
    for (int t = 0; t < WIN - 2; t++) tick();
    test_en_i = 1'b0; cyc();
    chk("R9", "idle from wait", pack_out(), 0);
    repeat (2 * WIN) tick();
    chk("R9", "no error while disabled", timeout_err_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule